// File: doc/BRIEF.md
# Multi-Mode ADC Result Readout Controller

This block stores the conversion results of six converter channels and returns them to a host over a parallel read bus. The six channels form three pairs: A0/A1, B0/B1 and C0/C1. The bus is synchronous to the block clock. It has an active-low chip select, an active-low read strobe and a 3-bit address input. That address input does two jobs: it picks a channel, or it picks one of two sequenced readout modes.

Each completed conversion arrives as a one-cycle event carrying a channel number and a 12-bit result. The host reads in one of three modes:

- Direct mode addresses one channel at a time.
- Cycle mode steps through all six channels in a fixed round-robin.
- FIFO mode returns results in the order the conversions finished. Up to three results per channel are kept.

A result that arrives while a read is in progress is not written straight away. It is parked and written once the strobe rises, so data never changes under an active read.

Top module: `adc_readout_ctrl`

## Requirements
- R1: A read starts on the first clock where `rd_n` is sampled low with `cs_n` low, after `rd_n` was high on the clock before. Address codes 000 to 101 return channel 0 to 5, which are A0, A1, B0, B1, C0 and C1. The read word is {tag[14:12] = channel number, result[11:0]}. It is valid from that clock edge on and stays unchanged until the next read starts.
- R2: Address code 110 selects cycle mode. Successive cycle reads return channels 0,1,2,3,4,5 and then wrap back to 0. The step to the next channel is taken at the clock that sees the strobe high again.
- R3: Address code 111 selects FIFO mode. Reads return the stored results in the order they were written. The FIFO holds 18 entries, three per channel. When it is full, a new result overwrites the oldest entry.
- R4: A FIFO-mode read from an empty FIFO returns an all-zero word and consumes nothing.
- R5: The address is captured as the current mode only at a read start. Strobe activity while `cs_n` is high neither changes the mode nor changes `rd_data`.
- R6: Synchronous reset has several effects. The captured mode becomes 000 and the cycle pointer returns to channel 0. The channel registers and `rd_data` are cleared, the FIFO is emptied, and parked results are discarded.
- R7: A result that arrives while the strobe is low with `cs_n` low, or during a read in progress, is not written until the read has ended. It is written once the strobe is high again.
- R8: Each channel has one parked slot. A second result for the same channel during one read replaces the first, so only the newest is written.
- R9: A result enters the FIFO only while the captured mode is 111. After reset, a read with address 111 must happen first.
- R10: A result event with channel number 6 or 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 3 | Channel address or mode code |
| res_valid | input | 1 | Conversion result event |
| res_chan | input | 3 | Channel number of the result |
| res_data | input | 12 | Conversion result |
| rd_data | output | 15 | Registered read word: {tag, result} |

## Verification
Two functions can fall in the same clock: a conversion result arriving, and a read being in progress. The bench provokes this by holding the strobe low for several clocks. While it is low, it sends two results for one channel and one result for another. It then judges the outcome through later direct reads. The parked channel must show its newest value, and the other channel must show its value. A second variant asserts reset during a long read that has a parked result. The parked result must then be gone.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int TAG_W = 3;
  localparam logic [TAG_W-1:0] MODE_CYC  = 3'b110;
  localparam logic [TAG_W-1:0] MODE_FIFO = 3'b111;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [TAG_W-1:0] addr,
  output logic             rd_start,
  output logic             rd_end,
  output logic             hold,
  output logic [TAG_W-1:0] mode_q,
  output logic [TAG_W-1:0] cyc_ptr
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(NCH - 1);

  logic rd_n_q;
  logic active_q;

  assign rd_start = rd_n_q & ~rd_n & ~cs_n;
  assign rd_end   = active_q & rd_n;
  assign hold     = active_q | (~rd_n & ~cs_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n_q   <= 1'b1;
      active_q <= 1'b0;
      mode_q   <= '0;
      cyc_ptr  <= '0;
    end else begin
      rd_n_q <= rd_n;
      if (rd_start) begin
        active_q <= 1'b1;
        mode_q   <= addr;
      end else if (rd_end) begin
        active_q <= 1'b0;
        if (mode_q == MODE_CYC)
          cyc_ptr <= (cyc_ptr == LAST) ? '0 : cyc_ptr + 1'b1;
      end
    end
  end

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (rst)
    cyc_ptr <= LAST); // R2
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    active_q |=> $stable(mode_q)); // R5
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_end && mode_q == MODE_CYC && cyc_ptr != LAST) |=> cyc_ptr == $past(cyc_ptr) + 1'b1); // R2
endmodule

// File: rtl/adc_rd_defer.sv
module adc_rd_defer
  import adc_rd_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_chan,
  input  logic [DW-1:0]    in_data,
  output logic             wr_valid,
  output logic [TAG_W-1:0] wr_chan,
  output logic [DW-1:0]    wr_data
);
  logic [NCH-1:0] pend_v;
  logic [DW-1:0]  pend_d [NCH];
  logic           in_ok;
  logic           any_pend;
  logic           direct;
  logic           flush;
  logic [TAG_W-1:0] fidx;

  assign in_ok    = in_valid && (in_chan < TAG_W'(NCH));
  assign any_pend = |pend_v;
  assign direct   = in_ok && !hold && !any_pend;
  assign flush    = !hold && any_pend;

  always_comb begin
    fidx = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_v[i]) fidx = TAG_W'(i);
  end

  always_comb begin
    wr_valid = direct | flush;
    wr_chan  = flush ? fidx : in_chan;
    wr_data  = flush ? pend_d[fidx] : in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
    end else begin
      if (flush) pend_v[fidx] <= 1'b0;
      if (in_ok && !direct) pend_v[in_chan] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ok && !direct) pend_d[in_chan] <= in_data;
  end

  AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    hold |-> !wr_valid); // R7
  AST_PARK_SET: assert property (@(posedge clk) disable iff (rst)
    (in_ok && hold) |=> pend_v[$past(in_chan)]); // R8
endmodule

// File: rtl/adc_rd_fifo.sv
module adc_rd_fifo #(
  parameter int WW    = 15,
  parameter int DEPTH = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [WW-1:0] push_data,
  input  logic          pop,
  output logic          empty,
  output logic [WW-1:0] head
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [WW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (push) begin
      wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (full) rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      else      cnt  <= cnt + 1'b1;
    end else if (pop && !empty) begin
      rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      cnt  <= cnt - 1'b1;
    end
  end

  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
    !(push && pop)); // R7
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R3
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (full && push) |=> full); // R3
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int DW   = 12,
  parameter int HIST = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic [TAG_W-1:0]    addr,
  input  logic                res_valid,
  input  logic [TAG_W-1:0]    res_chan,
  input  logic [DW-1:0]       res_data,
  output logic [TAG_W+DW-1:0] rd_data
);
  localparam int WW    = TAG_W + DW;
  localparam int DEPTH = NCH * HIST;

  logic             rd_start, rd_end, hold;
  logic [TAG_W-1:0] mode_q, cyc_ptr;
  logic             wr_valid;
  logic [TAG_W-1:0] wr_chan;
  logic [DW-1:0]    wr_data;
  logic             fifo_empty;
  logic [WW-1:0]    fifo_head;
  logic [DW-1:0]    ch_q [NCH];
  logic [WW-1:0]    rd_next;

  adc_rd_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
    .rd_start(rd_start), .rd_end(rd_end), .hold(hold),
    .mode_q(mode_q), .cyc_ptr(cyc_ptr)
  );

  adc_rd_defer #(.NCH(NCH), .DW(DW)) u_defer (
    .clk(clk), .rst(rst), .hold(hold),
    .in_valid(res_valid), .in_chan(res_chan), .in_data(res_data),
    .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_data(wr_data)
  );

  adc_rd_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(wr_valid && mode_q == MODE_FIFO),
    .push_data({wr_chan, wr_data}),
    .pop(rd_end && mode_q == MODE_FIFO),
    .empty(fifo_empty), .head(fifo_head)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst)
          ch_q[g] <= '0;
        else if (wr_valid && wr_chan == TAG_W'(g))
          ch_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (addr == MODE_FIFO)
      rd_next = fifo_empty ? '0 : fifo_head;
    else if (addr == MODE_CYC)
      rd_next = {cyc_ptr, ch_q[cyc_ptr]};
    else if (addr < TAG_W'(NCH))
      rd_next = {addr, ch_q[addr]};
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_data <= '0;
    else if (rd_start)  rd_data <= rd_next;
  end

  AST_DIRECT_TAG: assert property (@(posedge clk) disable iff (rst)
    (rd_start && addr < TAG_W'(NCH)) |=> rd_data[WW-1:DW] == $past(addr)); // R1
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_start |=> $stable(rd_data)); // R1
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_start && addr == MODE_FIFO && fifo_empty) |=> rd_data == '0); // R4
endmodule

// File: tb/test_adc_readout_ctrl.sv
module test_adc_readout_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [2:0]  addr = '0;
  logic        res_valid = 1'b0;
  logic [2:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic [14:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  adc_readout_ctrl i_adc_readout_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] ch, input logic [11:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [14:0] w);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    w = rd_data;
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 37 + 5) & 12'hFFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [14:0] w;
    logic [14:0] held;
    do_reset();
    chk("R6 reset rd_data", rd_data, 15'h0);
    rd(3'b110, w);
    chk("R6 first cycle read is A0 cleared", w, 15'h0);
    rd(3'b000, w);

    // R1: direct sweep
    for (int c = 0; c < 6; c++) put(3'(c), 12'h100 * 12'(c) + 12'h0A5);
    for (int c = 0; c < 6; c++) begin
      rd(3'(c), w);
      chk("R1 direct read", w, {3'(c), 12'h100 * 12'(c) + 12'h0A5});
    end

    // R2: cycle sweep with wrap, after reset pointer at 0
    do_reset();
    for (int c = 0; c < 6; c++) put(3'(c), 12'h800 + 12'(c));
    for (int k = 0; k < 14; k++) begin
      rd(3'b110, w);
      chk("R2 cycle order", w, {3'(k % 6), 12'h800 + 12'(k % 6)});
    end

    // R10: invalid channel ignored (direct regs unchanged)
    put(3'd6, 12'hFFF);
    put(3'd7, 12'hEEE);
    for (int c = 0; c < 6; c++) begin
      rd(3'(c), w);
      chk("R10 invalid channel ignored", w, {3'(c), 12'h800 + 12'(c)});
    end

    // R9: results before FIFO mode do not enter FIFO
    do_reset();
    put(3'd1, 12'h111); put(3'd2, 12'h222);
    rd(3'b111, w);
    chk("R9 no FIFO store before mode", w, 15'h0);
    rd(3'b111, w);
    chk("R4 empty FIFO read is zero", w, 15'h0);

    // R10 in FIFO mode
    put(3'd7, 12'h123);
    rd(3'b111, w);
    chk("R10 invalid channel not in FIFO", w, 15'h0);

    // R3: overflow by two, oldest overwritten
    for (int i = 0; i < 20; i++) put(3'(i % 6), pat(i));
    for (int i = 2; i < 20; i++) begin
      rd(3'b111, w);
      chk("R3 FIFO order", w, {3'(i % 6), pat(i)});
    end
    rd(3'b111, w);
    chk("R4 FIFO empty after drain", w, 15'h0);
    rd(3'b111, w);
    chk("R4 empty read consumes nothing", w, 15'h0);

    // R5: strobe with cs_n high neither reads nor changes mode
    put(3'd4, 12'h444);
    held = rd_data;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; addr = 3'b000;
    repeat (3) @(negedge clk);
    chk("R5 no read with cs_n high", rd_data, held);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    put(3'd5, 12'h555);
    rd(3'b111, w);
    chk("R5 mode kept, FIFO head", w, {3'd4, 12'h444});
    rd(3'b111, w);
    chk("R5 mode kept, FIFO second", w, {3'd5, 12'h555});

    // R7/R8: results during a long read
    do_reset();
    put(3'd1, 12'h010); put(3'd2, 12'h020);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 3'd1;
    @(negedge clk);
    held = rd_data;
    res_valid = 1'b1; res_chan = 3'd1; res_data = 12'hAAA;
    @(negedge clk); res_chan = 3'd2; res_data = 12'hBBB;
    @(negedge clk); res_chan = 3'd1; res_data = 12'hCCC;
    @(negedge clk); res_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 read word steady during read", rd_data, held);
    chk("R7 read word value", held, {3'd1, 12'h010});
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd1, w);
    chk("R8 newest parked result kept", w, {3'd1, 12'hCCC});
    rd(3'd2, w);
    chk("R7 parked result written after read", w, {3'd2, 12'hBBB});

    // R6: reset discards parked result
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 3'd0;
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'd3; res_data = 12'h333;
    @(negedge clk); res_valid = 1'b0;
    rst = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd3, w);
    chk("R6 parked result discarded", w, {3'd3, 12'h000});
    rd(3'd1, w);
    chk("R6 channel register cleared", w, {3'd1, 12'h000});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule